// File: doc/BRIEF.md
# ADC Channel Scan Sequencer

This block is the digital control logic in front of an eight-input analog-to-digital converter core. Software writes a control word made of a run bit, a scan-enable bit, a group-width bit and a 3-bit channel select. The block then steps through the chosen channels. For each channel it drives the channel index to the converter core and sends a one-cycle start strobe. It then waits for the core's done pulse and files the returned word in a result register for that channel. Any result register can be read through a channel-addressed read port.

Without scan, the block converts one channel and then clears the run bit itself. With scan, it cycles through the chosen group in ascending order and wraps back to the first channel of the group. It keeps doing this until software clears the run bit or a standby request arrives. A conversion-complete flag marks the end of a single conversion, or the end of each full pass through a scan group. Software clears this flag with a one-cycle clear pulse.

The sequencer has three states. In S_IDLE nothing is in flight. In S_ISSUE the start strobe is high for one cycle. In S_WAIT the block waits for done. The transitions are:
- S_IDLE to S_ISSUE on a start write.
- S_ISSUE to S_WAIT after one cycle.
- S_WAIT to S_ISSUE on done in scan mode.
- S_WAIT to S_IDLE on done in single mode.
- S_ISSUE or S_WAIT to S_IDLE on a stop write or a standby request.

Top module: `adc_scan_seq`

## Requirements
- R1: After reset the following are all zero: the run bit, the completion flag, the start strobe and every result register.
- R2: A write with `ctl_start`=1 made in idle raises `conv_start` for exactly one cycle, in the cycle after the write. Only one conversion is ever in flight: no further strobe is issued until the done for that conversion has been accepted.
- R3: With `ctl_scan`=0, the only channel converted is `ctl_sel`, read as a binary channel number, whatever the value of `ctl_wide`. When that conversion's done is accepted, the run bit drops to 0 and the completion flag sets.
- R4: With `ctl_scan`=1 and `ctl_wide`=0, `ctl_sel[2]` picks the bank: channels 0 to 3 or channels 4 to 7. The scan runs in ascending order from the first channel of that bank up to channel `ctl_sel`, then restarts at the first channel of the bank.
- R5: With `ctl_scan`=1 and `ctl_wide`=1, the scan runs in ascending order from channel 0 up to channel `ctl_sel`, then restarts at channel 0. With `ctl_sel`=000 this repeats channel 0 alone.
- R6: Each accepted done writes `conv_data` into the result register of the channel just converted. `rd_data` shows the register that `rd_ch` selects.
- R7: In scan mode the completion flag sets only when the done for the last channel of the group is accepted. `flag_clr` clears the flag. If a flag set and a `flag_clr` fall in the same cycle, the set wins.
- R8: A write with `ctl_start`=0 stops the run and returns the block to idle, with the run bit at 0. The result of the conversion in flight is discarded, even if its done arrives in the same cycle as the stop write.
- R9: While `standby` is high the run bit is held at 0 and the block stays idle. Start writes made during standby are ignored.
- R10: A write made while a run is active leaves the run bit at 1 and does not change the running channel group. The mode and select it carries are used only by the next start from idle.
- R11: A done pulse that arrives while no conversion is awaited changes no result register and does not set the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| standby | input | 1 | Standby request; forces the block to idle |
| ctl_wr | input | 1 | Control-word write strobe |
| ctl_start | input | 1 | Run bit value to write |
| ctl_scan | input | 1 | Scan enable value to write |
| ctl_wide | input | 1 | Group width value to write (0 = banks of four, 1 = one bank of eight) |
| ctl_sel | input | 3 | Channel select value to write |
| flag_clr | input | 1 | Clears the completion flag |
| conv_done | input | 1 | Done pulse from the converter core |
| conv_data | input | 10 | Result word from the converter core |
| rd_ch | input | 3 | Result register read address |
| start_bit | output | 1 | Current run bit |
| eoc_flag | output | 1 | Completion flag |
| conv_start | output | 1 | Start strobe to the converter core |
| conv_ch | output | 3 | Channel index to the converter core |
| rd_data | output | 10 | Result register selected by `rd_ch` |

## Verification
Two events can fall in the same cycle: the converter's done being accepted, and a software stop write. Their outcomes conflict, since one files a result and may set the flag, while the other discards the conversion. The bench provokes this by issuing the stop write at the very negative edge at which its converter model is already holding done high. It then judges the outcome at the port: the run bit must be 0, the flag must stay clear, that channel's result register must still hold its old value, and no further start strobe may appear. A second collision, flag set against `flag_clr`, is provoked the same way on a single conversion, and the flag must read 1 afterwards.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;
    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_ISSUE = 2'd1,
        S_WAIT  = 2'd2
    } seq_state_t;
endpackage

// File: rtl/adc_group_decode.sv
module adc_group_decode #(
    parameter int CH_W = 3
) (
    input  logic            scan,
    input  logic            wide,
    input  logic [CH_W-1:0] sel,
    output logic [CH_W-1:0] first,
    output logic [CH_W-1:0] last
);
    // The last channel is always the select value; only the start point moves.
    always_comb begin
        last = sel;
        if (!scan)
            first = sel;
        else if (wide)
            first = '0;
        else
            first = {sel[CH_W-1], {(CH_W-1){1'b0}}};
    end
endmodule

// File: rtl/adc_result_bank.sv
module adc_result_bank #(
    parameter int CH_W = 3,
    parameter int DW   = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [CH_W-1:0] wr_ch,
    input  logic [DW-1:0]   wr_data,
    input  logic [CH_W-1:0] rd_ch,
    output logic [DW-1:0]   rd_data
);
    localparam int NCH = 1 << CH_W;

    logic [DW-1:0] regs [NCH];

    for (genvar g = 0; g < NCH; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                regs[g] <= '0;
            else if (wr_en && wr_ch == CH_W'(g))
                regs[g] <= wr_data;
        end
    end

    assign rd_data = regs[rd_ch];

    // R6: an accepted result lands in the addressed slot
    a_r6_store: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> regs[$past(wr_ch)] == $past(wr_data));
endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
    import adc_scan_pkg::*;
#(
    parameter int CH_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            standby,
    input  logic            ctl_wr,
    input  logic            ctl_start,
    input  logic            ctl_scan,
    input  logic [CH_W-1:0] grp_first,
    input  logic [CH_W-1:0] grp_last,
    input  logic            flag_clr,
    input  logic            conv_done,
    output logic            start_bit,
    output logic            eoc_flag,
    output logic            conv_start,
    output logic [CH_W-1:0] conv_ch,
    output logic            store_en
);
    seq_state_t      state, nxt;
    logic            act_scan;
    logic [CH_W-1:0] act_first, act_last, cur_ch;
    logic            stop_req, go_req, accept, at_end;

    assign stop_req = standby | (ctl_wr & ~ctl_start);
    assign go_req   = ctl_wr & ctl_start & ~standby;
    assign accept   = (state == S_WAIT) & conv_done & ~stop_req;
    assign at_end   = (cur_ch == act_last);

    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:  if (go_req) nxt = S_ISSUE;
            S_ISSUE: nxt = stop_req ? S_IDLE : S_WAIT;
            S_WAIT: begin
                if (stop_req)
                    nxt = S_IDLE;
                else if (conv_done)
                    nxt = act_scan ? S_ISSUE : S_IDLE;
            end
            default: nxt = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= S_IDLE;
        else
            state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_bit <= 1'b0;
            eoc_flag  <= 1'b0;
            act_scan  <= 1'b0;
            act_first <= '0;
            act_last  <= '0;
            cur_ch    <= '0;
        end else begin
            if (stop_req)
                start_bit <= 1'b0;
            else if (state == S_IDLE && go_req)
                start_bit <= 1'b1;
            else if (accept && !act_scan)
                start_bit <= 1'b0;

            if (accept && (!act_scan || at_end))
                eoc_flag <= 1'b1;
            else if (flag_clr)
                eoc_flag <= 1'b0;

            if (state == S_IDLE && go_req) begin
                act_scan  <= ctl_scan;
                act_first <= grp_first;
                act_last  <= grp_last;
                cur_ch    <= grp_first;
            end else if (accept && act_scan) begin
                cur_ch <= at_end ? act_first : cur_ch + 1'b1;
            end
        end
    end

    always_comb begin
        conv_start = (state == S_ISSUE);
        conv_ch    = cur_ch;
        store_en   = accept;
    end

    // R2: the start strobe lasts one cycle
    a_r2_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start);
    // R3: a single conversion drops the run bit when it completes
    a_r3_single_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_WAIT && conv_done && !stop_req && !act_scan) |=> !start_bit);
    // R4 / R5: the running channel stays inside the captured group
    a_r4_ch_in_group: assert property (@(posedge clk) disable iff (!rst_n)
        start_bit |-> (cur_ch >= act_first && cur_ch <= act_last));
    // R7: the flag only rises on an accepted done
    a_r7_eoc_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(eoc_flag) |-> $past(state == S_WAIT && conv_done));
    // R8: a stop write returns the block to idle
    a_r8_stop_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && !ctl_start) |=> (!start_bit && state == S_IDLE));
    // R9: standby forces idle
    a_r9_standby_idle: assert property (@(posedge clk) disable iff (!rst_n)
        standby |=> (!start_bit && state == S_IDLE));
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq #(
    parameter int CH_W = 3,
    parameter int DW   = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            standby,
    input  logic            ctl_wr,
    input  logic            ctl_start,
    input  logic            ctl_scan,
    input  logic            ctl_wide,
    input  logic [CH_W-1:0] ctl_sel,
    input  logic            flag_clr,
    input  logic            conv_done,
    input  logic [DW-1:0]   conv_data,
    input  logic [CH_W-1:0] rd_ch,
    output logic            start_bit,
    output logic            eoc_flag,
    output logic            conv_start,
    output logic [CH_W-1:0] conv_ch,
    output logic [DW-1:0]   rd_data
);
    logic [CH_W-1:0] grp_first, grp_last;
    logic            store_en;

    adc_group_decode #(.CH_W(CH_W)) u_decode (
        .scan  (ctl_scan),
        .wide  (ctl_wide),
        .sel   (ctl_sel),
        .first (grp_first),
        .last  (grp_last)
    );

    adc_seq_fsm #(.CH_W(CH_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .standby    (standby),
        .ctl_wr     (ctl_wr),
        .ctl_start  (ctl_start),
        .ctl_scan   (ctl_scan),
        .grp_first  (grp_first),
        .grp_last   (grp_last),
        .flag_clr   (flag_clr),
        .conv_done  (conv_done),
        .start_bit  (start_bit),
        .eoc_flag   (eoc_flag),
        .conv_start (conv_start),
        .conv_ch    (conv_ch),
        .store_en   (store_en)
    );

    adc_result_bank #(.CH_W(CH_W), .DW(DW)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (store_en),
        .wr_ch   (conv_ch),
        .wr_data (conv_data),
        .rd_ch   (rd_ch),
        .rd_data (rd_data)
    );
endmodule

// File: tb/adc_scan_seq_test.sv
module adc_scan_seq_test;
    localparam int CH_W = 3;
    localparam int DW   = 10;
    localparam int NCH  = 1 << CH_W;
    localparam int LAT  = 3;

    logic clk = 1'b0;
    logic rst_n, standby, ctl_wr, ctl_start, ctl_scan, ctl_wide, flag_clr;
    logic [CH_W-1:0] ctl_sel, rd_ch;
    logic conv_done;
    logic [DW-1:0] conv_data;
    logic start_bit, eoc_flag, conv_start;
    logic [CH_W-1:0] conv_ch;
    logic [DW-1:0] rd_data;

    int checks = 0;
    int errors = 0;
    int exp_q[$];
    string cur_tag = "R2";
    logic [DW-1:0] exp_mem [NCH];

    int cnt;
    int seq;
    logic [CH_W-1:0] m_ch;

    always #10 clk = ~clk;

    adc_scan_seq #(.CH_W(CH_W), .DW(DW)) uut (
        .clk(clk), .rst_n(rst_n), .standby(standby), .ctl_wr(ctl_wr),
        .ctl_start(ctl_start), .ctl_scan(ctl_scan), .ctl_wide(ctl_wide),
        .ctl_sel(ctl_sel), .flag_clr(flag_clr), .conv_done(conv_done),
        .conv_data(conv_data), .rd_ch(rd_ch), .start_bit(start_bit),
        .eoc_flag(eoc_flag), .conv_start(conv_start), .conv_ch(conv_ch),
        .rd_data(rd_data)
    );

    function automatic logic [DW-1:0] sample_val(int ch, int s);
        return DW'(ch * 53 + s * 7 + 1);
    endfunction

    // Converter model: fixed latency from strobe to done
    always @(posedge clk) begin
        if (!rst_n) begin
            cnt <= 0; seq <= 0; m_ch <= '0;
            conv_done <= 1'b0; conv_data <= '0;
        end else begin
            conv_done <= 1'b0;
            if (cnt > 0) begin
                cnt <= cnt - 1;
                if (cnt == 1) begin
                    conv_done <= 1'b1;
                    conv_data <= sample_val(int'(m_ch), seq);
                    seq <= seq + 1;
                end
            end
            if (conv_start) begin
                cnt  <= LAT;
                m_ch <= conv_ch;
            end
        end
    end

    task automatic chk(string tag, bit ok, int act, int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
        end
    endtask

    // Scoreboard monitor: every start strobe must match the next expected channel
    always @(negedge clk) begin
        if (rst_n && conv_start) begin
            if (exp_q.size() == 0) begin
                chk({cur_tag, " unexpected start"}, 1'b0, int'(conv_ch), -1);
            end else begin
                int e;
                e = exp_q.pop_front();
                chk({cur_tag, " channel order"}, int'(conv_ch) == e, int'(conv_ch), e);
            end
        end
    end

    task automatic wr_now(bit st, bit sc, bit wd, int sel);
        ctl_wr = 1'b1; ctl_start = st; ctl_scan = sc; ctl_wide = wd;
        ctl_sel = CH_W'(sel);
        @(negedge clk);
        ctl_wr = 1'b0;
    endtask

    task automatic pulse_clr();
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
    endtask

    task automatic wait_done();
        do @(negedge clk); while (conv_done !== 1'b1);
    endtask

    task automatic chk_rd(string tag, int ch);
        rd_ch = CH_W'(ch);
        #1;
        chk(tag, rd_data == exp_mem[ch], int'(rd_data), int'(exp_mem[ch]));
    endtask

    task automatic settle_empty(string tag);
        repeat (LAT + 3) @(negedge clk);
        chk({tag, " no further starts"}, exp_q.size() == 0, exp_q.size(), 0);
    endtask

    task automatic run_single(string tag, bit wd, int sel, bit clr_at_done);
        cur_tag = tag;
        pulse_clr();
        exp_q.push_back(sel);
        wr_now(1'b1, 1'b0, wd, sel);
        chk("R2 strobe after start write", conv_start == 1'b1, conv_start, 1);
        wait_done();
        exp_mem[int'(m_ch)] = conv_data;
        if (clr_at_done) flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
        chk({tag, " run bit self-clears"}, start_bit == 1'b0, start_bit, 0);
        chk({tag, " flag set"}, eoc_flag == 1'b1, eoc_flag, 1);
        chk_rd("R6 single result", sel);
        settle_empty(tag);
    endtask

    task automatic run_scan(string tag, bit wd, int sel, int ndone, bit mid);
        int first, gsize;
        first = wd ? 0 : (sel & 4);
        gsize = sel - first + 1;
        cur_tag = tag;
        pulse_clr();
        for (int i = 0; i <= ndone; i++) exp_q.push_back(first + (i % gsize));
        wr_now(1'b1, 1'b1, wd, sel);
        chk("R2 strobe after start write", conv_start == 1'b1, conv_start, 1);
        for (int k = 1; k <= ndone; k++) begin
            wait_done();
            exp_mem[int'(m_ch)] = conv_data;
            @(negedge clk);
            chk({tag, " run bit held in scan"}, start_bit == 1'b1, start_bit, 1);
            chk("R7 flag once per pass", eoc_flag == (k >= gsize), eoc_flag, int'(k >= gsize));
            if (mid && k == 1) wr_now(1'b1, 1'b0, 1'b0, 7);
        end
        wr_now(1'b0, 1'b0, 1'b0, 0);
        chk("R8 stop clears run bit", start_bit == 1'b0, start_bit, 0);
        settle_empty(tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; standby = 1'b0; ctl_wr = 1'b0; ctl_start = 1'b0;
        ctl_scan = 1'b0; ctl_wide = 1'b0; ctl_sel = '0; flag_clr = 1'b0;
        rd_ch = '0;
        for (int i = 0; i < NCH; i++) exp_mem[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        chk("R1 run bit", start_bit == 1'b0, start_bit, 0);
        chk("R1 flag", eoc_flag == 1'b0, eoc_flag, 0);
        chk("R1 strobe", conv_start == 1'b0, conv_start, 0);
        for (int i = 0; i < NCH; i++) chk_rd("R1 result cleared", i);

        run_single("R3", 1'b1, 5, 1'b0);
        run_single("R7 set beats clear", 1'b0, 2, 1'b1);
        pulse_clr();
        chk("R7 flag cleared", eoc_flag == 1'b0, eoc_flag, 0);

        run_scan("R4", 1'b0, 6, 5, 1'b0);
        run_scan("R4", 1'b0, 1, 4, 1'b0);
        run_scan("R5", 1'b1, 7, 9, 1'b0);
        run_scan("R10", 1'b0, 3, 5, 1'b1);
        run_scan("R5", 1'b1, 0, 2, 1'b0);

        // R8: stop write lands in the same cycle as done
        cur_tag = "R8";
        pulse_clr();
        exp_q.push_back(4);
        wr_now(1'b1, 1'b1, 1'b0, 5);
        wait_done();
        wr_now(1'b0, 1'b0, 1'b0, 0);
        chk("R8 run bit after collision", start_bit == 1'b0, start_bit, 0);
        chk("R8 flag after collision", eoc_flag == 1'b0, eoc_flag, 0);
        chk_rd("R8 discarded result", 4);
        settle_empty("R8");

        // R9 and R11: standby aborts; the late done is ignored
        cur_tag = "R9";
        exp_q.push_back(0);
        wr_now(1'b1, 1'b1, 1'b1, 2);
        @(negedge clk);
        standby = 1'b1;
        @(negedge clk);
        chk("R9 run bit under standby", start_bit == 1'b0, start_bit, 0);
        wr_now(1'b1, 1'b1, 1'b1, 2);
        standby = 1'b0;
        chk("R9 start ignored in standby", start_bit == 1'b0, start_bit, 0);
        chk("R9 no strobe", conv_start == 1'b0, conv_start, 0);
        settle_empty("R9");
        chk_rd("R11 late done ignored", 0);
        chk("R11 flag untouched", eoc_flag == 1'b0, eoc_flag, 0);

        for (int i = 0; i < NCH; i++) chk_rd("R6 final results", i);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule